// File: doc/BRIEF.md
# Per-Rail Power-Good Qualifier

This block works out one regulator rail's share of a combined power-good output. Each cycle it reads the rail's enable, its digitised voltage and current comparator results, a flag for a voltage-setting change in progress, the regulator's sequencing phase and a flag for a pending fault shutdown. From these it forms a raw "rail is healthy" condition. That condition is then filtered against a slow time-base tick before it reaches the registered `good` output.

Configuration inputs set three things. The first is whether the rail is monitored, and if so whether the load current counts along with the voltage. The second is whether over-voltage counts along with under-voltage. The third is which of two valid-delay lengths applies. A rail that is unmonitored, or disabled with no fault pending, is masked: it reports good at once, so it never holds down a wired-together power-good net. Every other change of `good` has to survive a debounce window counted in ticks. The window for going not-good and the window for going good are set apart.

Top module: `rail_pg_qualifier`

## Requirements
- R1: When `mon_sel` is 2'b00, `good` is 1 from the next clock edge, whatever the other inputs are.
- R2: When `rail_en` is 0 and `fault_pend` is 0 on a monitored rail, `good` is 1 from the next clock edge, with no debounce.
- R3: When `fault_pend` is 1 on a monitored rail, the condition is unhealthy even if `rail_en` is 0. `good` falls through the normal invalid filter and then stays 0.
- R4: With `win_both` at 0, only `uv` makes the condition unhealthy and `ov` is ignored. With `win_both` at 1, either `uv` or `ov` makes it unhealthy.
- R5: With `mon_sel` at 2'b01, `ilim` is ignored. With `mon_sel` at 2'b10 or 2'b11, `ilim` at 1 makes the condition unhealthy.
- R6: The `phase` values 1 (start-up delay), 2 (soft start) and 3 (ramp-up) make the condition unhealthy, and so does `dvs_busy` at 1. The values 4 (shutdown delay) and 5 (ramp-down) make it healthy whatever the comparators say. The values 0, 6 and 7 mean regulation, where the comparators decide.
- R7: After `good` is 1, it goes to 0 on the clock edge of the INV_TICKS-th tick cycle in which the unhealthy condition has held without a break.
- R8: After `good` is 0, it goes to 1 on the clock edge of the N-th healthy tick cycle in a row. N is VALID_SHORT_TICKS when `slow_valid` is 0 and VALID_LONG_TICKS when it is 1.
- R9: If the condition returns to match `good` before the window expires, the count starts again from zero. A glitch shorter than the window never reaches `good`.
- R10: Reset leaves `good` at 0. Outside the masked cases, `good` changes only on a clock edge where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Filter time-base enable, one cycle wide |
| rail_en | input | 1 | Regulator enabled |
| uv | input | 1 | Output below lower window limit |
| ov | input | 1 | Output above upper window limit |
| ilim | input | 1 | Forward current limit active |
| dvs_busy | input | 1 | Output ramping to a new set point |
| phase | input | 3 | Sequencing phase (see R6) |
| fault_pend | input | 1 | Rail shut down by a fault whose interrupt is still pending |
| mon_sel | input | 2 | 00 unmonitored, 01 voltage only, 1x voltage and current |
| win_both | input | 1 | 0 under-voltage only, 1 both window edges |
| slow_valid | input | 1 | Selects the long valid delay |
| good | output | 1 | Debounced rail power-good contribution |

## Verification
Two things can land in the same cycle: the rail is disabled, which would mask it good at once, and a fault shutdown is flagged, which must keep it not-good. The bench drops `rail_en` and raises `fault_pend` on the same edge while `good` is 1. It then checks that `good` holds until the invalid window runs out and does not jump or stay high. It also checks that clearing the monitor select in that state still forces good on the next edge. A second case has a one-tick healthy glitch arriving just before the invalid window expires, and the bench checks that the count starts again instead of running on.

// File: rtl/rail_pg_qualifier.sv
module rail_pg_qualifier #(
  parameter int INV_TICKS         = 7,
  parameter int VALID_SHORT_TICKS = 10,
  parameter int VALID_LONG_TICKS  = 80,
  localparam int MAX_TICKS = (INV_TICKS > VALID_SHORT_TICKS) ?
                             ((INV_TICKS > VALID_LONG_TICKS) ? INV_TICKS : VALID_LONG_TICKS) :
                             ((VALID_SHORT_TICKS > VALID_LONG_TICKS) ? VALID_SHORT_TICKS : VALID_LONG_TICKS),
  localparam int CW = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rail_en,
  input  logic       uv,
  input  logic       ov,
  input  logic       ilim,
  input  logic       dvs_busy,
  input  logic [2:0] phase,
  input  logic       fault_pend,
  input  logic [1:0] mon_sel,
  input  logic       win_both,
  input  logic       slow_valid,
  output logic       good
);

  localparam logic [2:0] PH_RUN   = 3'd0;
  localparam logic [2:0] PH_SDLY  = 3'd1;
  localparam logic [2:0] PH_SOFT  = 3'd2;
  localparam logic [2:0] PH_RAMP  = 3'd3;
  localparam logic [2:0] PH_OFFD  = 3'd4;
  localparam logic [2:0] PH_RDOWN = 3'd5;

  logic          forced;
  logic          volt_ok, cur_ok, healthy;
  logic [CW-1:0] cnt, target;

  assign forced  = (mon_sel == 2'b00) || (!rail_en && !fault_pend);
  assign volt_ok = !uv && !(win_both && ov);
  assign cur_ok  = !(mon_sel[1] && ilim);

  always_comb begin
    case (phase)
      PH_SDLY, PH_SOFT, PH_RAMP: healthy = 1'b0;
      PH_OFFD, PH_RDOWN:         healthy = 1'b1;
      default:                   healthy = volt_ok && cur_ok && !dvs_busy;
    endcase
    if (fault_pend) healthy = 1'b0;
  end

  assign target = good       ? CW'(INV_TICKS) :
                  slow_valid ? CW'(VALID_LONG_TICKS) : CW'(VALID_SHORT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good <= 1'b0;
      cnt  <= '0;
    end else if (forced) begin
      good <= 1'b1;
      cnt  <= '0;
    end else if (healthy == good) begin
      cnt  <= '0;
    end else if (tick) begin
      if (cnt + CW'(1) >= target) begin
        good <= ~good;
        cnt  <= '0;
      end else begin
        cnt  <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rail_pg_qualifier_chk.sv
module rail_pg_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rail_en,
  input logic       fault_pend,
  input logic [1:0] mon_sel,
  input logic       good
);

  // R1
  unmon_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 2'b00) |=> good);

  // R2
  masked_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel != 2'b00 && !rail_en && !fault_pend) |=> good);

  // R3
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel != 2'b00 && fault_pend && !good) |=> !good);

  // R10
  notick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && mon_sel != 2'b00 && (rail_en || fault_pend)) |=> $stable(good));

  // R7
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(good) |-> $past(tick));

endmodule

bind rail_pg_qualifier rail_pg_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rail_en(rail_en),
  .fault_pend(fault_pend), .mon_sel(mon_sel), .good(good)
);

// File: tb/rail_pg_qualifier_tb.sv
module rail_pg_qualifier_tb;
  localparam int INV = 3;
  localparam int VS  = 4;
  localparam int VL  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rail_en = 1'b1, uv = 1'b0, ov = 1'b0, ilim = 1'b0;
  logic dvs_busy = 1'b0, fault_pend = 1'b0, win_both = 1'b0, slow_valid = 1'b0;
  logic [2:0] phase = 3'd0;
  logic [1:0] mon_sel = 2'b01;
  logic good;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rail_pg_qualifier #(.INV_TICKS(INV), .VALID_SHORT_TICKS(VS), .VALID_LONG_TICKS(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rail_en(rail_en), .uv(uv), .ov(ov),
    .ilim(ilim), .dvs_busy(dvs_busy), .phase(phase), .fault_pend(fault_pend),
    .mon_sel(mon_sel), .win_both(win_both), .slow_valid(slow_valid), .good(good));

  // {req[3:0], phase[2:0], en, uv, ov, ilim, dvs, fault, sel[1:0], win, exp}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    17'b0100_000_1_0_0_0_0_0_01_0_1,  // R4 clean rail
    17'b0100_000_1_1_0_0_0_0_01_0_0,  // R4 under-voltage
    17'b0100_000_1_0_1_0_0_0_01_0_1,  // R4 ov ignored, window low only
    17'b0100_000_1_0_1_0_0_0_01_1_0,  // R4 ov counted
    17'b0101_000_1_0_0_1_0_0_01_0_1,  // R5 ilim ignored
    17'b0101_000_1_0_0_1_0_0_10_0_0,  // R5 ilim counted
    17'b0101_000_1_0_0_1_0_0_11_0_0,  // R5 ilim counted
    17'b0110_000_1_0_0_0_1_0_01_0_0,  // R6 set-point change
    17'b0110_001_1_0_0_0_0_0_01_0_0,  // R6 start-up delay
    17'b0110_010_1_0_0_0_0_0_01_0_0,  // R6 soft start
    17'b0110_011_1_0_0_0_0_0_01_0_0,  // R6 ramp-up
    17'b0110_100_1_1_0_0_0_0_01_0_1,  // R6 shutdown delay
    17'b0110_101_1_1_0_0_0_0_01_0_1,  // R6 ramp-down
    17'b0010_000_0_1_0_0_0_0_01_0_1,  // R2 disabled masked
    17'b0001_000_1_1_0_0_0_1_00_0_1,  // R1 unmonitored
    17'b0011_000_0_0_0_0_0_1_10_0_0,  // R3 disabled by fault
    17'b0011_000_1_0_0_0_0_1_01_0_0   // R3 fault pending
  };

  task automatic chk(input logic exp, input string req, input string what);
    checks++;
    if (good !== exp) begin
      fails++;
      $display("FAIL %s %s: good=%b expected=%b", req, what, good, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic healthy_run();
    @(negedge clk);
    phase = 3'd0; rail_en = 1'b1; uv = 1'b0; ov = 1'b0; ilim = 1'b0;
    dvs_busy = 1'b0; fault_pend = 1'b0; mon_sel = 2'b01; win_both = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1'b0, "R10", "reset state, no ticks");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {phase, rail_en, uv, ov, ilim, dvs_busy, fault_pend, mon_sel, win_both} = VEC[v][13:1];
      ticks(VL + 2);
      chk(VEC[v][0], $sformatf("R%0d", VEC[v][16:13]), $sformatf("vector %0d", v));
    end

    healthy_run(); slow_valid = 1'b0;
    ticks(VL + 2);
    uv = 1'b1;
    ticks(INV - 1);
    chk(1'b1, "R7", "one tick before invalid expiry");
    ticks(1);
    chk(1'b0, "R7", "invalid expiry");

    uv = 1'b0; slow_valid = 1'b0;
    ticks(VS - 1);
    chk(1'b0, "R8", "one tick before short valid expiry");
    ticks(1);
    chk(1'b1, "R8", "short valid expiry");

    uv = 1'b1; ticks(INV);
    uv = 1'b0; slow_valid = 1'b1;
    ticks(VL - 1);
    chk(1'b0, "R8", "one tick before long valid expiry");
    ticks(1);
    chk(1'b1, "R8", "long valid expiry");

    uv = 1'b1; ticks(INV - 1);
    uv = 1'b0; ticks(1);
    uv = 1'b1; ticks(INV - 1);
    chk(1'b1, "R9", "glitch restarts invalid count");
    ticks(1);
    chk(1'b0, "R9", "full window after restart");

    uv = 1'b1; repeat (40) @(negedge clk);
    uv = 1'b0; repeat (40) @(negedge clk);
    chk(1'b0, "R10", "no change without ticks");

    // same-cycle: disable and fault pending together
    healthy_run(); slow_valid = 1'b0;
    ticks(VS + 1);
    chk(1'b1, "R3", "rail good before shutdown");
    @(negedge clk); rail_en = 1'b0; fault_pend = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b1, "R3", "fault not instant");
    ticks(INV);
    chk(1'b0, "R3", "fault overrides disable mask");
    mon_sel = 2'b00;
    @(negedge clk);
    chk(1'b1, "R1", "unmonitored overrides fault");
    mon_sel = 2'b10; fault_pend = 1'b0;
    @(negedge clk);
    chk(1'b1, "R2", "disabled without fault masked");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule